// File: doc/BRIEF.md
# Four-Channel External Interrupt Unit

This block watches four asynchronous input pins and turns selected activity on them into latched interrupt requests. Each channel is configured through a small register port. A mode bit picks between level sensitivity and edge sensitivity. A polarity bit picks which level (low or high) or which edge (falling or rising) counts as active. Each pin is brought into the clock domain through a two-flop synchronizer before any detection is done.

A detected event sets the channel's flag. The flag drives that channel's interrupt request output, and any set flag raises a single wake output used by power control. Software clears a flag by writing a one to its bit. In level mode that clear is overridden for as long as the pin stays at its active level. A per-channel function-select input, driven by the pin multiplexer, gates whether a channel can set its flag at all. Reconfiguring mode or polarity can create a flag that software must then clear.

Top module: `eic_ctrl`

## Requirements
- R1: After reset the flag, mode and polarity registers all read 0, every interrupt request is low and the wake output is low.
- R2: In level mode (mode bit 0), a channel's flag is set while its synchronized pin equals its polarity bit (1 = active high, 0 = active low). The flag appears on the outputs three clock edges after the pin changes.
- R3: In edge mode (mode bit 1), polarity 1 sets the flag on a rising edge of the synchronized pin and polarity 0 sets it on a falling edge. The opposite edge leaves the flag unchanged.
- R4: A write to the flag register (word index 0) clears each flag whose data bit is 1 and leaves flags with a data bit of 0 unchanged. An edge-mode flag is cleared even while the pin stays high.
- R5: In level mode, a clear write has no effect while the pin is at its active level. Once the pin is inactive, the flag stays set until it is cleared.
- R6: A channel whose function-select input is 0 never sets its flag, whatever its pin does.
- R7: Interrupt request bit i equals flag bit i, and the wake output is high when any flag is set.
- R8: A write to the mode register (word index 1) or the polarity register (word index 2) that makes a level channel's current pin active sets its flag. Restoring the old setting does not clear that flag.
- R9: The previous-sample register updates every cycle, so switching a steady pin's channel into edge mode does not set its flag.
- R10: Bits 31:4 of every register read as 0, word index 3 reads as 0, and the mode and polarity registers read back their stored bits 3:0. Read data is combinational on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| func_sel | input | 4 | Per-channel enable from pin multiplexing |
| reg_addr | input | 2 | Register word index (0 flag, 1 mode, 2 polarity) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_req | output | 4 | Per-channel interrupt requests |
| wake_req | output | 1 | Wake request, high when any flag is set |

## Verification
The bench tries to clear a level flag while its pin is still active. A design that lets the clear win would drop the request and lose a pending level interrupt. It also changes polarity so that a level pin becomes active, then restores the old setting: a design that auto-cleared spurious flags, or gated setting on configuration writes, would show no flag or drop it. A steady-high pin is switched into rising-edge mode, where a design whose previous sample froze outside edge mode would report a phantom edge. Finally, the bench drives the opposite edge and toggles pins on deselected channels, which catches inverted polarity decoding and missing function-select gating.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int FLAG_IDX = 0;
  localparam int MODE_IDX = 1;
  localparam int POL_IDX  = 2;

  // level active: pin equals polarity
  function automatic logic lvl_active(logic pol, logic cur);
    return (cur == pol);
  endfunction

  // selected edge between previous and current sample
  function automatic logic edge_seen(logic pol, logic cur, logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // next flag value: set has priority over a one-to-clear
  function automatic logic flag_next(logic cur_flag, logic set, logic clr);
    return set | (cur_flag & ~clr);
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_sync,
  input  logic [NUM_CH-1:0] mode,
  input  logic [NUM_CH-1:0] pol,
  input  logic [NUM_CH-1:0] func_sel,
  output logic [NUM_CH-1:0] set_evt,
  output logic [NUM_CH-1:0] level_hold
);
  logic [NUM_CH-1:0] prev_q;

  // previous sample tracks the pin in every mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic lvl_hit;
      logic edg_hit;
      always_comb begin
        lvl_hit = func_sel[c] & ~mode[c] & lvl_active(pol[c], pin_sync[c]);
        edg_hit = func_sel[c] &  mode[c] & edge_seen(pol[c], pin_sync[c], prev_q[c]);
      end
      assign level_hold[c] = lvl_hit;
      assign set_evt[c]    = lvl_hit | edg_hit;
    end
  endgenerate
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NUM_CH-1:0] set_evt,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] flag,
  output logic [NUM_CH-1:0] mode,
  output logic [NUM_CH-1:0] pol,
  output logic [NUM_CH-1:0] clr_hit
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_IDX);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_IDX);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(POL_IDX);

  logic [NUM_CH-1:0] flag_q, mode_q, pol_q;
  logic wr_flag, wr_mode, wr_pol;

  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_pol  = reg_wr && (reg_addr == A_POL);
  assign clr_hit = wr_flag ? reg_wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[NUM_CH-1:0];
      if (wr_pol)  pol_q  <= reg_wdata[NUM_CH-1:0];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[c] <= 1'b0;
        else        flag_q[c] <= flag_next(flag_q[c], set_evt[c], clr_hit[c]);
      end
    end
  endgenerate

  always_comb begin
    case (reg_addr)
      A_FLAG:  reg_rdata = DATA_W'(flag_q);
      A_MODE:  reg_rdata = DATA_W'(mode_q);
      A_POL:   reg_rdata = DATA_W'(pol_q);
      default: reg_rdata = '0;
    endcase
  end

  assign flag = flag_q;
  assign mode = mode_q;
  assign pol  = pol_q;
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl #(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [NUM_CH-1:0] func_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] irq_req,
  output logic              wake_req
);
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] set_evt;
  logic [NUM_CH-1:0] level_hold;
  logic [NUM_CH-1:0] flag, mode, pol, clr_hit;

  eic_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  eic_detect #(.NUM_CH(NUM_CH)) i_detect (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .mode(mode), .pol(pol),
    .func_sel(func_sel), .set_evt(set_evt), .level_hold(level_hold)
  );

  eic_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .set_evt(set_evt), .reg_rdata(reg_rdata),
    .flag(flag), .mode(mode), .pol(pol), .clr_hit(clr_hit)
  );

  assign irq_req  = flag;
  assign wake_req = |flag;
endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] func_sel,
  input logic [NUM_CH-1:0] irq_req,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NUM_CH-1:0] set_evt,
  input logic [NUM_CH-1:0] level_hold
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R5
      level_flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_hold[c] |=> irq_req[c]);
      // R4
      clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req[c]) |-> $past(reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[c]));
      // R6
      rise_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req[c]) |-> $past(func_sel[c]));
      // R3
      rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req[c]) |-> $past(set_evt[c]));
    end
  endgenerate

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_CH] == '0);
endmodule

bind eic_ctrl eic_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .func_sel(func_sel), .irq_req(irq_req),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .set_evt(set_evt), .level_hold(level_hold)
);

// File: tb/test_eic_ctrl.sv
module test_eic_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_in = 4'h0;
  logic [3:0]  func_sel = 4'h0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_req;
  logic        wake_req;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    int          kind;   // 0: {wake,irq}, 1: register read
    logic [31:0] exp;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  eic_ctrl i_eic_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .func_sel(func_sel),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .wake_req(wake_req)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? {27'h0, wake_req, irq_req} : reg_rdata;
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic exp_rd(input string tag, input logic [1:0] a, input logic [31:0] e);
    item_t it;
    reg_addr = a;
    #1;
    it.tag = tag; it.kind = 1; it.exp = e;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic exp_out(input string tag, input logic [31:0] e);
    item_t it;
    it.tag = tag; it.kind = 0; it.exp = e;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic set_pins(input logic [3:0] p);
    @(negedge clk);
    pin_in = p;
    settle();
  endtask

  // watchdog
  initial begin
    #2000000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    exp_rd("R1 flag", 2'd0, 32'h0);
    exp_rd("R1 mode", 2'd1, 32'h0);
    exp_rd("R1 pol", 2'd2, 32'h0);
    exp_out("R1 outputs", 32'h0);
    // R10 unmapped index
    exp_rd("R10 index3", 2'd3, 32'h0);

    // ch0 level high, ch1 level low, ch2 rising, ch3 falling
    wr(2'd1, 32'hFFFF_FFFC);
    wr(2'd2, 32'h0000_0005);
    exp_rd("R10 mode readback", 2'd1, 32'hC);
    exp_rd("R10 pol readback", 2'd2, 32'h5);
    set_pins(4'b1010);
    // R6 deselected channels: level active and rising edge
    set_pins(4'b1111);
    exp_rd("R6 no flag when deselected", 2'd0, 32'h0);
    set_pins(4'b1010);
    func_sel = 4'hF;
    settle();
    exp_out("R7 idle outputs", 32'h0);

    // R2 active high level
    set_pins(4'b1011);
    exp_rd("R2 level high sets", 2'd0, 32'h1);
    exp_out("R7 irq and wake", 32'h11);
    // R5 clear blocked while active
    wr(2'd0, 32'h1);
    settle();
    exp_rd("R5 clear blocked", 2'd0, 32'h1);
    set_pins(4'b1010);
    exp_rd("R5 stays after inactive", 2'd0, 32'h1);
    wr(2'd0, 32'h1);
    settle();
    exp_rd("R5 clear when inactive", 2'd0, 32'h0);
    // R2 active low level
    set_pins(4'b1000);
    exp_rd("R2 level low sets", 2'd0, 32'h2);
    set_pins(4'b1010);
    wr(2'd0, 32'h2);
    settle();
    exp_rd("R2 cleared", 2'd0, 32'h0);

    // R3 rising edge on ch2
    set_pins(4'b1110);
    exp_rd("R3 rising sets", 2'd0, 32'h4);
    wr(2'd0, 32'h4);
    settle();
    exp_rd("R4 edge clear with pin high", 2'd0, 32'h0);
    set_pins(4'b1010);
    exp_rd("R3 opposite edge ignored", 2'd0, 32'h0);
    // R3 falling edge on ch3
    set_pins(4'b0010);
    exp_rd("R3 falling sets", 2'd0, 32'h8);
    wr(2'd0, 32'h0);
    settle();
    exp_rd("R4 zero write keeps", 2'd0, 32'h8);
    wr(2'd0, 32'h8);
    settle();
    exp_rd("R4 one clears", 2'd0, 32'h0);
    set_pins(4'b1010);
    exp_rd("R3 rise on falling channel", 2'd0, 32'h0);

    // R8 polarity change makes ch0 active low with pin low
    wr(2'd2, 32'h4);
    settle();
    exp_rd("R8 spurious flag", 2'd0, 32'h1);
    wr(2'd2, 32'h5);
    settle();
    exp_rd("R8 not auto-cleared", 2'd0, 32'h1);
    wr(2'd0, 32'h1);
    settle();
    exp_rd("R8 cleared", 2'd0, 32'h0);

    // R9 ch1 pin steady high, switch to edge then rising
    wr(2'd1, 32'hE);
    wr(2'd2, 32'h7);
    settle();
    exp_rd("R9 no phantom edge", 2'd0, 32'h0);
    set_pins(4'b1000);
    exp_rd("R9 falling ignored", 2'd0, 32'h0);
    set_pins(4'b1010);
    exp_rd("R3 rising on switched channel", 2'd0, 32'h2);
    wr(2'd0, 32'h2);
    settle();

    // R7 two channels at once
    set_pins(4'b1111);
    exp_out("R7 two flags", 32'h15);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule